// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block watches a 36-bit data port that is split into four 9-bit lanes. The most significant bit of each lane is that lane's parity bit. One select input chooses odd or even parity. The block checks every lane of the incoming word that the current bus size uses. It drives an active-low error output when any of those lanes is wrong. The error output is purely combinational and keeps no memory of earlier words.

The same per-lane parity trees also serve the outgoing direction. During a mailbox read with generation enabled, the trees are fed the outgoing mailbox word instead of the incoming data. Each lane's parity bit in the outgoing word is replaced with a freshly computed bit, and the error output is held inactive whatever the input pins carry. In every other case the mailbox word passes through unchanged.

A two-bit size code selects the bus size: full width, half width or quarter width. For the narrow sizes, an endianness input chooses whether the upper or the lower lanes are the ones in use.

Top module: `byte_lane_parity`

## Requirements
- R1: Lane k occupies bits [9k+8:9k]. Bit 9k+8 is that lane's parity bit and bits [9k+7:9k] are its data.
- R2: With odd_sel=1 a lane passes when its 9 bits hold an odd number of ones. With odd_sel=0 it passes when they hold an even number of ones.
- R3: When generation is not active, err_n is 0 exactly when at least one checked lane fails, and 1 otherwise.
- R4: size_sel=2'b00 (full width) checks all four lanes.
- R5: size_sel=2'b01 (half width) checks lanes 3 and 2 when big_end=1, and lanes 1 and 0 when big_end=0. The other two lanes have no effect on err_n.
- R6: size_sel=2'b10 or 2'b11 (quarter width) checks only lane 3 when big_end=1, and only lane 0 when big_end=0. The other lanes have no effect on err_n.
- R7: Generation is active when cs_n=0, en=1, wr=0, mbox_sel=1 and gen_en=1 all hold together. While it is active, err_n=1 whatever din carries. Removing any one of these conditions ends the forcing.
- R8: While generation is active, dout keeps the 8 data bits of every lane of mbox_data. Each parity bit is replaced so that the lane meets the parity chosen by odd_sel.
- R9: While generation is not active, dout equals mbox_data bit for bit.
- R10: err_n depends only on the present inputs. A failing word followed by a passing word gives err_n=1 with no delay and no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Port select, active low |
| en | input | 1 | Transfer enable, active high |
| wr | input | 1 | Direction: 1 write, 0 read |
| mbox_sel | input | 1 | Selects the mailbox register for the transfer |
| gen_en | input | 1 | Requests parity generation on mailbox reads |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| size_sel | input | 2 | Bus size: 00 full, 01 half, 1x quarter |
| big_end | input | 1 | For narrow sizes, 1 uses the upper lanes and 0 the lower |
| din | input | 36 | Incoming word to be checked |
| mbox_data | input | 36 | Outgoing mailbox word |
| dout | output | 36 | Outgoing word, with parity bits replaced when generating |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The checker's assertions are sampled combinationally. They assume that every input has settled before they are evaluated, and they make no assumption about the order in which inputs change. The stimulus therefore drives all inputs together, well clear of the bench clock's sampling edge, and never leaves a pin undriven or unknown. The assertions also assume that odd_sel applies to both checking and generation at the same moment. The stimulus changes odd_sel only together with the rest of a vector, never partway through a check.

// File: rtl/bl_parity_pkg.sv
package bl_parity_pkg;

   // Bus size codes; both quarter codes behave the same.
   typedef enum logic [1:0] {
      BUS_FULL    = 2'b00,
      BUS_HALF    = 2'b01,
      BUS_QUARTER = 2'b10,
      BUS_QTR_ALT = 2'b11
   } bus_size_e;

   localparam int unsigned DEF_LANE_DATA_W = 8;
   localparam int unsigned DEF_LANE_COUNT  = 4;

endpackage

// File: rtl/bl_lane_mask.sv
module bl_lane_mask
   import bl_parity_pkg::*;
#(
   parameter int unsigned LANE_COUNT = DEF_LANE_COUNT
) (
   input  logic [1:0]            size_sel,
   input  logic                  big_end,
   output logic [LANE_COUNT-1:0] lane_used
);
   localparam int unsigned HALF_N = LANE_COUNT / 2;
   localparam int unsigned QTR_N  = LANE_COUNT / 4;

   generate
      if (LANE_COUNT % 4 != 0 || LANE_COUNT == 0) begin : g_bad_count
         $error("bl_lane_mask: LANE_COUNT must be a nonzero multiple of 4");
      end
   endgenerate

   bus_size_e size_code;
   assign size_code = bus_size_e'(size_sel);

   for (genvar k = 0; k < LANE_COUNT; k++) begin : g_lane
      logic in_half;
      logic in_qtr;
      assign in_half = big_end ? (k >= LANE_COUNT - HALF_N) : (k < HALF_N);
      assign in_qtr  = big_end ? (k >= LANE_COUNT - QTR_N)  : (k < QTR_N);
      always_comb begin
         unique case (size_code)
            BUS_FULL:                lane_used[k] = 1'b1;
            BUS_HALF:                lane_used[k] = in_half;
            BUS_QUARTER, BUS_QTR_ALT: lane_used[k] = in_qtr;
            default:                 lane_used[k] = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/bl_parity_tree.sv
module bl_parity_tree
   import bl_parity_pkg::*;
#(
   parameter int unsigned LANE_DATA_W = DEF_LANE_DATA_W,
   localparam int unsigned LANE_W     = LANE_DATA_W + 1
) (
   input  logic [LANE_W-1:0] lane,
   input  logic              odd_sel,
   output logic              lane_fail,
   output logic              gen_bit
);
   generate
      if (LANE_DATA_W < 1) begin : g_bad_width
         $error("bl_parity_tree: LANE_DATA_W must be at least 1");
      end
   endgenerate

   logic data_x;
   assign data_x    = ^lane[LANE_DATA_W-1:0];
   // Parity bit that makes the whole lane meet the chosen sense.
   assign gen_bit   = data_x ^ odd_sel;
   assign lane_fail = (data_x ^ lane[LANE_W-1]) != odd_sel;
endmodule

// File: rtl/bl_parity_merge.sv
module bl_parity_merge
   import bl_parity_pkg::*;
#(
   parameter int unsigned LANE_DATA_W = DEF_LANE_DATA_W,
   parameter int unsigned LANE_COUNT  = DEF_LANE_COUNT,
   localparam int unsigned LANE_W     = LANE_DATA_W + 1,
   localparam int unsigned BUS_W      = LANE_W * LANE_COUNT
) (
   input  logic [BUS_W-1:0]      mbox_data,
   input  logic [LANE_COUNT-1:0] gen_bits,
   input  logic                  gen_act,
   output logic [BUS_W-1:0]      dout
);
   for (genvar k = 0; k < LANE_COUNT; k++) begin : g_lane
      assign dout[k*LANE_W +: LANE_DATA_W] = mbox_data[k*LANE_W +: LANE_DATA_W];
      assign dout[k*LANE_W + LANE_DATA_W]  =
         gen_act ? gen_bits[k] : mbox_data[k*LANE_W + LANE_DATA_W];
   end
endmodule

// File: rtl/byte_lane_parity.sv
module byte_lane_parity
   import bl_parity_pkg::*;
#(
   parameter int unsigned LANE_DATA_W = DEF_LANE_DATA_W,
   parameter int unsigned LANE_COUNT  = DEF_LANE_COUNT,
   localparam int unsigned LANE_W     = LANE_DATA_W + 1,
   localparam int unsigned BUS_W      = LANE_W * LANE_COUNT
) (
   input  logic             cs_n,
   input  logic             en,
   input  logic             wr,
   input  logic             mbox_sel,
   input  logic             gen_en,
   input  logic             odd_sel,
   input  logic [1:0]       size_sel,
   input  logic             big_end,
   input  logic [BUS_W-1:0] din,
   input  logic [BUS_W-1:0] mbox_data,
   output logic [BUS_W-1:0] dout,
   output logic             err_n
);
   logic                  gen_act;
   logic [BUS_W-1:0]      tree_in;
   logic [LANE_COUNT-1:0] lane_used;
   logic [LANE_COUNT-1:0] lane_fail;
   logic [LANE_COUNT-1:0] gen_bits;

   assign gen_act = !cs_n && en && !wr && mbox_sel && gen_en;
   // One set of trees: fed by the mailbox word when generating.
   assign tree_in = gen_act ? mbox_data : din;

   bl_lane_mask #(.LANE_COUNT(LANE_COUNT)) mask_i (
      .size_sel  (size_sel),
      .big_end   (big_end),
      .lane_used (lane_used)
   );

   for (genvar k = 0; k < LANE_COUNT; k++) begin : g_tree
      bl_parity_tree #(.LANE_DATA_W(LANE_DATA_W)) tree_i (
         .lane      (tree_in[k*LANE_W +: LANE_W]),
         .odd_sel   (odd_sel),
         .lane_fail (lane_fail[k]),
         .gen_bit   (gen_bits[k])
      );
   end

   bl_parity_merge #(.LANE_DATA_W(LANE_DATA_W), .LANE_COUNT(LANE_COUNT)) merge_i (
      .mbox_data (mbox_data),
      .gen_bits  (gen_bits),
      .gen_act   (gen_act),
      .dout      (dout)
   );

   assign err_n = gen_act ? 1'b1 : !(|(lane_fail & lane_used));
endmodule

// File: rtl/byte_lane_parity_chk.sv
module byte_lane_parity_chk #(
   parameter int unsigned LANE_DATA_W = 8,
   parameter int unsigned LANE_COUNT  = 4,
   localparam int unsigned LANE_W     = LANE_DATA_W + 1,
   localparam int unsigned BUS_W      = LANE_W * LANE_COUNT
) (
   input logic             cs_n,
   input logic             en,
   input logic             wr,
   input logic             mbox_sel,
   input logic             gen_en,
   input logic             odd_sel,
   input logic [BUS_W-1:0] mbox_data,
   input logic [BUS_W-1:0] dout,
   input logic             err_n
);
   logic gen_req;
   assign gen_req = (cs_n == 1'b0) && (en == 1'b1) && (wr == 1'b0) &&
                    (mbox_sel == 1'b1) && (gen_en == 1'b1);

   always_comb begin
      // R7
      gen_forces_flag_chk: assert (!gen_req || err_n == 1'b1)
         else $error("err_n low while generating");
      // R9
      pass_through_chk: assert (gen_req || dout == mbox_data)
         else $error("dout differs from mailbox word while not generating");
   end

   for (genvar k = 0; k < LANE_COUNT; k++) begin : g_lane_chk
      always_comb begin
         // R8
         gen_lane_parity_chk: assert (!gen_req || (^dout[k*LANE_W +: LANE_W]) == odd_sel)
            else $error("generated lane %0d has wrong parity", k);
         // R8
         gen_data_keep_chk: assert (!gen_req ||
               dout[k*LANE_W +: LANE_DATA_W] == mbox_data[k*LANE_W +: LANE_DATA_W])
            else $error("generated lane %0d data changed", k);
      end
   end
endmodule

bind byte_lane_parity byte_lane_parity_chk #(
   .LANE_DATA_W(LANE_DATA_W),
   .LANE_COUNT (LANE_COUNT)
) chk_i (
   .cs_n      (cs_n),
   .en        (en),
   .wr        (wr),
   .mbox_sel  (mbox_sel),
   .gen_en    (gen_en),
   .odd_sel   (odd_sel),
   .mbox_data (mbox_data),
   .dout      (dout),
   .err_n     (err_n)
);

// File: tb/byte_lane_parity_tb_top.sv
`timescale 1ns/1ps
module byte_lane_parity_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        cs_n, en, wr, mbox_sel, gen_en, odd_sel, big_end;
   logic [1:0]  size_sel;
   logic [35:0] din, mbox_data, dout;
   logic        err_n;

   int total = 0;
   int bad   = 0;

   byte_lane_parity dut_i (
      .cs_n(cs_n), .en(en), .wr(wr), .mbox_sel(mbox_sel), .gen_en(gen_en),
      .odd_sel(odd_sel), .size_sel(size_sel), .big_end(big_end),
      .din(din), .mbox_data(mbox_data), .dout(dout), .err_n(err_n)
   );

   // {din, size, big_end, odd, expected err_n, requirement number}
   localparam int NV = 16;
   localparam logic [48:0] VEC [NV] = '{
      {36'h000000000, 2'b00, 1'b0, 1'b0, 1'b1, 8'd2},  // R2 even, all zero
      {36'h000000000, 2'b00, 1'b0, 1'b1, 1'b0, 8'd2},  // R2 odd, all zero
      {36'h804020100, 2'b00, 1'b0, 1'b1, 1'b1, 8'd4},  // R4
      {36'h804020100, 2'b00, 1'b0, 1'b0, 1'b0, 8'd4},  // R4
      {36'h000000100, 2'b00, 1'b0, 1'b0, 1'b0, 8'd3},  // R3
      {36'h000000100, 2'b10, 1'b0, 1'b0, 1'b0, 8'd6},  // R6
      {36'h000000100, 2'b10, 1'b0, 1'b1, 1'b1, 8'd6},  // R6
      {36'h000000100, 2'b10, 1'b1, 1'b0, 1'b1, 8'd6},  // R6
      {36'h000000100, 2'b10, 1'b1, 1'b1, 1'b0, 8'd6},  // R6
      {36'h000000100, 2'b01, 1'b0, 1'b1, 1'b0, 8'd5},  // R5
      {36'h000000100, 2'b01, 1'b1, 1'b0, 1'b1, 8'd5},  // R5
      {36'h000020100, 2'b01, 1'b0, 1'b1, 1'b1, 8'd5},  // R5
      {36'h000020100, 2'b01, 1'b1, 1'b1, 1'b0, 8'd5},  // R5
      {36'h800000000, 2'b10, 1'b1, 1'b1, 1'b1, 8'd1},  // R1 parity bit at top of lane 3
      {36'h000000001, 2'b10, 1'b0, 1'b1, 1'b1, 8'd1},  // R1 data bit 0 of lane 0
      {36'h000000001, 2'b11, 1'b0, 1'b0, 1'b0, 8'd6}   // R6 alternate quarter code
   };

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected outgoing word when generating (R8): data kept, parity recomputed.
   function automatic logic [35:0] gen_word(input logic [35:0] w, input logic odd);
      logic [35:0] r = w;
      for (int k = 0; k < 4; k++) r[9*k+8] = (^w[9*k +: 8]) ^ odd;
      return r;
   endfunction

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      cs_n = 1'b1; en = 1'b0; wr = 1'b0; mbox_sel = 1'b0; gen_en = 1'b0;
      odd_sel = 1'b0; size_sel = 2'b00; big_end = 1'b0;
      din = '0; mbox_data = '0;
   endtask

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle();
      settle();
      // Idle state: all-zero word passes even parity, dout is the mailbox word (R3, R9)
      check("R3 idle", {35'd0, err_n}, 36'd1);
      check("R9 idle", dout, 36'd0);

      for (int i = 0; i < NV; i++) begin
         din       = VEC[i][48:13];
         size_sel  = VEC[i][12:11];
         big_end   = VEC[i][10];
         odd_sel   = VEC[i][9];
         mbox_data = ~VEC[i][48:13];
         settle();
         check($sformatf("R%0d vec%0d", VEC[i][7:0], i), {35'd0, err_n}, {35'd0, VEC[i][8]});
         check("R9 vec pass", dout, ~VEC[i][48:13]);
      end

      // R7: generation forces err_n high even for failing din
      idle();
      cs_n = 1'b0; en = 1'b1; wr = 1'b0; mbox_sel = 1'b1; gen_en = 1'b1;
      odd_sel = 1'b1; din = 36'h0; mbox_data = 36'h0000000FF;
      settle();
      check("R7 forced", {35'd0, err_n}, 36'd1);
      check("R8 gen odd", dout, gen_word(36'h0000000FF, 1'b1));

      odd_sel = 1'b0; mbox_data = 36'hFEDCBA987;
      settle();
      check("R8 gen even", dout, gen_word(36'hFEDCBA987, 1'b0));
      check("R7 forced even", {35'd0, err_n}, 36'd1);

      // R7: removing any one condition ends the forcing; din fails odd parity
      odd_sel = 1'b1; din = 36'h0;
      for (int c = 0; c < 5; c++) begin
         cs_n = (c == 0); en = (c != 1); wr = (c == 2); mbox_sel = (c != 3); gen_en = (c != 4);
         settle();
         check($sformatf("R7 cond%0d", c), {35'd0, err_n}, 36'd0);
         check("R9 no gen", dout, 36'hFEDCBA987);
      end

      // R10: failing then passing input, no memory
      idle();
      odd_sel = 1'b1; din = 36'h0;
      settle();
      check("R10 fail", {35'd0, err_n}, 36'd0);
      din = 36'h804020100;
      #1;
      check("R10 recover", {35'd0, err_n}, 36'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule